// File: doc/BRIEF.md
# Watchdog Timer with Postscaler

This block is a watchdog that counts on its own free-running watchdog clock. That clock is independent of the system clock, so counting goes on while the core sleeps. A base counter of `BASE_CYCLES` watchdog-clock cycles sets the nominal period, for example 18 ms. When software assigns the postscaler to the watchdog, the period is multiplied by a power-of-two ratio from 1 up to 128. Clearing the watchdog, or entering sleep, zeroes both counters. A timeout has one of two effects: in normal operation it asks for a device reset, and while the device is in sleep mode it asks for a wake-up.

Clear and sleep-entry strobes come from the system clock domain. They are merged into one restart request and carried into the watchdog domain by a four-phase request/acknowledge handshake. A second handshake carries timeout events back, where they become single-cycle request pulses. The same timeout also pulls an active-low status flag low, and that flag stays low until power-on reset. Configuration inputs (enable, assign flag, ratio select) are treated as quasi-static and are read directly in the watchdog domain.

Top module: `wdt_timer`

## Requirements
- R1: While `rst_n` is low and right after it rises, `to_n` is 1 and `rst_req` and `wake_req` are 0.
- R2: With `cfg_en`=1, `ps_assign`=0 and `sleep_mode`=0, `rst_req` pulses once `BASE_CYCLES` watchdog-clock cycles after the last restart, plus at most the synchroniser latency and never earlier.
- R3: With `ps_assign`=1, a value k on `ps_sel` gives a timeout of `BASE_CYCLES` * 2^k watchdog-clock cycles after the last restart (k=0 gives 1:1, k=7 gives 1:128).
- R4: With `ps_assign`=0, `ps_sel` has no effect and the ratio is 1:1.
- R5: A `clr_stb` pulse restarts both counters. Strobes spaced closer than one timeout period prevent any request.
- R6: A `sleep_stb` pulse restarts both counters exactly as `clr_stb` does.
- R7: A timeout while `sleep_mode`=1 pulses `wake_req` and does not pulse `rst_req`.
- R8: Any timeout drives `to_n` to 0. It stays 0, through later restarts, until `rst_n` is asserted.
- R9: While `cfg_en`=0 no timeout occurs: neither request pulses and `to_n` keeps its value.
- R10: After a timeout the counters restart from zero, so with no restart the next timeout follows one full period later.
- R11: `rst_req` and `wake_req` are each high for one system-clock cycle per timeout and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock (may stop in sleep) |
| wdt_clk | input | 1 | Free-running watchdog clock |
| rst_n | input | 1 | Active-low power-on reset for both domains |
| cfg_en | input | 1 | Configuration enable; 0 disables the watchdog |
| ps_assign | input | 1 | 1 applies the postscaler ratio to the watchdog |
| ps_sel | input | PS_SEL_W | Ratio exponent k, ratio 2^k |
| clr_stb | input | 1 | Clear command strobe, system domain |
| sleep_stb | input | 1 | Sleep-entry command strobe, system domain |
| sleep_mode | input | 1 | High while the device is in sleep |
| rst_req | output | 1 | Device-reset request pulse, system domain |
| wake_req | output | 1 | Wake-up request pulse, system domain |
| to_n | output | 1 | Active-low timeout status flag |

## Verification
The assertions assume that `cfg_en`, `ps_assign` and `ps_sel` change only while no timeout is close. They also assume that `sleep_mode` is steady for a few watchdog cycles around each timeout, and that the system clock keeps running long enough for a request pulse to arrive. The stimulus respects these assumptions. Before each measurement it disables the watchdog, waits until any event still in flight has landed, and only then changes the configuration and `sleep_mode`. It re-enables together with a restart strobe and holds every setting until the expected request has been seen.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    // Classification of a timeout in the watchdog domain.
    typedef enum logic [1:0] {
        EVT_NONE  = 2'd0,
        EVT_RESET = 2'd1,
        EVT_WAKE  = 2'd2
    } wdt_evt_e;

    // Lane positions on the watchdog-to-system event crossing.
    localparam int unsigned LANE_RST  = 0;
    localparam int unsigned LANE_WAKE = 1;
    localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/wdt_hs_xfer.sv
`timescale 1ns/1ps
// Four-phase request/acknowledge pulse crossing, one lane per bit.
// A pulse arriving while a lane is busy is held as pending and sent later.
module wdt_hs_xfer #(
    parameter int unsigned LANES = 1
) (
    input  logic             src_clk,
    input  logic             dst_clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] src_pulse,
    output logic [LANES-1:0] dst_pulse
);

    typedef struct packed {
        logic [LANES-1:0] pend;
        logic [LANES-1:0] req;
        logic [LANES-1:0] ack1;
        logic [LANES-1:0] ack2;
    } src_st_t;

    typedef struct packed {
        logic [LANES-1:0] r1;
        logic [LANES-1:0] r2;
        logic [LANES-1:0] r3;
        logic [LANES-1:0] pls;
    } dst_st_t;

    src_st_t s_d, s_q;
    dst_st_t t_d, t_q;

    // Source side: launch, hold until acknowledged, then wait for release.
    always_comb begin
        logic [LANES-1:0] want;
        logic [LANES-1:0] launch;
        s_d      = s_q;
        s_d.ack1 = t_q.r2;
        s_d.ack2 = s_q.ack1;
        want     = s_q.pend | src_pulse;
        launch   = want & ~s_q.req & ~s_q.ack2;
        for (int i = 0; i < int'(LANES); i++) begin
            if (s_q.req[i]) begin
                s_d.req[i] = ~s_q.ack2[i];
            end else begin
                s_d.req[i] = launch[i];
            end
        end
        s_d.pend = want & ~launch;
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Destination side: two-flop sync of req, edge detect into a pulse.
    always_comb begin
        t_d     = t_q;
        t_d.r1  = s_q.req;
        t_d.r2  = t_q.r1;
        t_d.r3  = t_q.r2;
        t_d.pls = t_q.r2 & ~t_q.r3;
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign dst_pulse = t_q.pls;

endmodule

// File: rtl/wdt_count_core.sv
`timescale 1ns/1ps
// Base counter plus postscaler, clocked by the watchdog clock.
module wdt_count_core
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_CYCLES = 576,
    parameter int unsigned PS_SEL_W    = 3
) (
    input  logic                wdt_clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic                ps_assign,
    input  logic [PS_SEL_W-1:0] ps_sel,
    input  logic                kick,
    input  logic                sleep_async,
    output wdt_evt_e            evt
);

    localparam int unsigned BASE_W   = (BASE_CYCLES > 1) ? $clog2(BASE_CYCLES) : 1;
    localparam int unsigned PS_CNT_W = (1 << PS_SEL_W) - 1;
    localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(BASE_CYCLES - 1);

    typedef struct packed {
        logic [BASE_W-1:0]   base;
        logic [PS_CNT_W-1:0] ps;
        logic [1:0]          slp;
        wdt_evt_e            evt;
    } core_st_t;

    core_st_t d, q;
    logic [PS_CNT_W-1:0] ps_last;

    always_comb begin
        d       = q;
        d.slp   = {q.slp[0], sleep_async};
        d.evt   = EVT_NONE;
        ps_last = ps_assign ? PS_CNT_W'((32'd1 << ps_sel) - 32'd1) : '0;
        if (!cfg_en || kick) begin
            d.base = '0;
            d.ps   = '0;
        end else if (q.base >= BASE_LAST) begin
            d.base = '0;
            if (q.ps >= ps_last) begin
                d.ps  = '0;
                d.evt = q.slp[1] ? EVT_WAKE : EVT_RESET;
            end else begin
                d.ps = q.ps + 1'b1;
            end
        end else begin
            d.base = q.base + 1'b1;
        end
    end

    always_ff @(posedge wdt_clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{base: '0, ps: '0, slp: '0, evt: EVT_NONE};
        end else begin
            q <= d;
        end
    end

    assign evt = q.evt;

endmodule

// File: rtl/wdt_status_sys.sv
`timescale 1ns/1ps
// System-domain request outputs and the sticky active-low timeout flag.
module wdt_status_sys (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic rst_hit,
    input  logic wake_hit,
    output logic rst_req,
    output logic wake_req,
    output logic to_n
);

    typedef struct packed {
        logic rst;
        logic wake;
        logic to_n;
    } stat_st_t;

    stat_st_t d, q;

    always_comb begin
        d      = q;
        d.rst  = rst_hit;
        d.wake = wake_hit & ~rst_hit;
        d.to_n = q.to_n & ~(rst_hit | wake_hit);
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{rst: 1'b0, wake: 1'b0, to_n: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign rst_req  = q.rst;
    assign wake_req = q.wake;
    assign to_n     = q.to_n;

endmodule

// File: rtl/wdt_timer.sv
`timescale 1ns/1ps
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_CYCLES = 576,
    parameter int unsigned PS_SEL_W    = 3
) (
    input  logic                sys_clk,
    input  logic                wdt_clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic                ps_assign,
    input  logic [PS_SEL_W-1:0] ps_sel,
    input  logic                clr_stb,
    input  logic                sleep_stb,
    input  logic                sleep_mode,
    output logic                rst_req,
    output logic                wake_req,
    output logic                to_n
);

    logic                 kick_sys;
    logic                 kick_w;
    wdt_evt_e             core_evt;
    logic [NUM_LANES-1:0] evt_w;
    logic [NUM_LANES-1:0] evt_s;

    // Either command restarts the counters; one crossing serves both.
    assign kick_sys = clr_stb | sleep_stb;

    wdt_hs_xfer #(.LANES(1)) u_kick_xfer (
        .src_clk   (sys_clk),
        .dst_clk   (wdt_clk),
        .rst_n     (rst_n),
        .src_pulse (kick_sys),
        .dst_pulse (kick_w)
    );

    wdt_count_core #(
        .BASE_CYCLES (BASE_CYCLES),
        .PS_SEL_W    (PS_SEL_W)
    ) u_core (
        .wdt_clk     (wdt_clk),
        .rst_n       (rst_n),
        .cfg_en      (cfg_en),
        .ps_assign   (ps_assign),
        .ps_sel      (ps_sel),
        .kick        (kick_w),
        .sleep_async (sleep_mode),
        .evt         (core_evt)
    );

    always_comb begin
        evt_w            = '0;
        evt_w[LANE_RST]  = (core_evt == EVT_RESET);
        evt_w[LANE_WAKE] = (core_evt == EVT_WAKE);
    end

    wdt_hs_xfer #(.LANES(NUM_LANES)) u_evt_xfer (
        .src_clk   (wdt_clk),
        .dst_clk   (sys_clk),
        .rst_n     (rst_n),
        .src_pulse (evt_w),
        .dst_pulse (evt_s)
    );

    wdt_status_sys u_status (
        .sys_clk  (sys_clk),
        .rst_n    (rst_n),
        .rst_hit  (evt_s[LANE_RST]),
        .wake_hit (evt_s[LANE_WAKE]),
        .rst_req  (rst_req),
        .wake_req (wake_req),
        .to_n     (to_n)
    );

endmodule

// File: rtl/wdt_timer_chk.sv
`timescale 1ns/1ps
module wdt_timer_chk
    import wdt_pkg::*;
(
    input logic     sys_clk,
    input logic     wdt_clk,
    input logic     rst_n,
    input logic     cfg_en,
    input logic     rst_req,
    input logic     wake_req,
    input logic     to_n,
    input wdt_evt_e core_evt
);

    p_rst_one_cycle_r11: assert property (@(posedge sys_clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_wake_one_cycle_r11: assert property (@(posedge sys_clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    p_req_exclusive_r11: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !(rst_req && wake_req));

    p_flag_on_reset_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
        rst_req |-> !to_n);

    p_flag_on_wake_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
        wake_req |-> !to_n);

    p_flag_sticky_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !to_n |=> !to_n);

    p_quiet_disabled_r9: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        !cfg_en |=> (core_evt == EVT_NONE));

endmodule

bind wdt_timer wdt_timer_chk u_chk (
    .sys_clk  (sys_clk),
    .wdt_clk  (wdt_clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .rst_req  (rst_req),
    .wake_req (wake_req),
    .to_n     (to_n),
    .core_evt (core_evt)
);

// File: tb/tb_wdt_timer.sv
`timescale 1ns/1ps
module tb_wdt_timer;

    localparam int    BASE    = 32;
    localparam int    PSW     = 3;
    localparam longint WPER   = 70;    // watchdog clock period, ns
    localparam longint SPER   = 20;    // 50 MHz system clock
    localparam longint SLACK  = 1000;  // crossing latency allowance, ns

    logic           sys_clk = 1'b0;
    logic           wdt_clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_en = 1'b0;
    logic           ps_assign = 1'b0;
    logic [PSW-1:0] ps_sel = '0;
    logic           clr_stb = 1'b0;
    logic           sleep_stb = 1'b0;
    logic           sleep_mode = 1'b0;
    logic           rst_req;
    logic           wake_req;
    logic           to_n;

    wdt_timer #(.BASE_CYCLES(BASE), .PS_SEL_W(PSW)) dut (
        .sys_clk    (sys_clk),
        .wdt_clk    (wdt_clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .ps_assign  (ps_assign),
        .ps_sel     (ps_sel),
        .clr_stb    (clr_stb),
        .sleep_stb  (sleep_stb),
        .sleep_mode (sleep_mode),
        .rst_req    (rst_req),
        .wake_req   (wake_req),
        .to_n       (to_n)
    );

    always #10 sys_clk = ~sys_clk;
    initial begin
        #7;
        forever #35 wdt_clk = ~wdt_clk;
    end

    int     vectors = 0;
    int     errors = 0;
    int     rst_cnt = 0;
    int     wake_cnt = 0;
    int     long_cnt = 0;
    int     both_cnt = 0;
    longint rst_t = 0;
    longint wake_t = 0;
    longint t_kick = 0;
    logic   prev_r = 1'b0;
    logic   prev_w = 1'b0;

    // Output monitor, sampled away from the active edge.
    always @(negedge sys_clk) begin
        if (rst_req) begin
            rst_cnt++;
            rst_t = longint'($time);
        end
        if (wake_req) begin
            wake_cnt++;
            wake_t = longint'($time);
        end
        if ((rst_req && prev_r) || (wake_req && prev_w)) long_cnt++;
        if (rst_req && wake_req) both_cnt++;
        prev_r = rst_req;
        prev_w = wake_req;
    end

    function automatic longint period_ns(input bit a, input int sel);
        return longint'(BASE) * (a ? (longint'(1) << sel) : longint'(1)) * WPER;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input bit use_sleep);
        @(negedge sys_clk);
        if (use_sleep) sleep_stb = 1'b1;
        else clr_stb = 1'b1;
        t_kick = longint'($time);
        @(negedge sys_clk);
        clr_stb   = 1'b0;
        sleep_stb = 1'b0;
    endtask

    // Disable, let in-flight events land, then configure and re-enable.
    task automatic setup(input bit a, input int sel, input bit slp);
        @(negedge sys_clk);
        cfg_en = 1'b0;
        repeat (60) @(negedge sys_clk);
        ps_assign  = a;
        ps_sel     = PSW'(sel);
        sleep_mode = slp;
        cfg_en     = 1'b1;
    endtask

    // Restart, then expect exactly one request of the right kind after T.
    task automatic measure(input bit a, input int sel, input bit slp, input int pre_kicks,
                           input bit kick_sleep, input string req);
        longint T;
        longint dly;
        int     r0;
        int     w0;
        int     n;
        T = period_ns(a, sel);
        setup(a, sel, slp);
        for (int k = 0; k < pre_kicks; k++) begin
            r0 = rst_cnt;
            w0 = wake_cnt;
            strobe(kick_sleep);
            repeat (int'((T * 6) / (10 * SPER))) @(negedge sys_clk);
            check((rst_cnt == r0) && (wake_cnt == w0), req,
                  longint'(rst_cnt + wake_cnt - r0 - w0), 0);
        end
        r0 = rst_cnt;
        w0 = wake_cnt;
        strobe(kick_sleep);
        n = 0;
        while (rst_cnt == r0 && wake_cnt == w0 && n < int'(T / SPER) + 200) begin
            @(negedge sys_clk);
            n++;
        end
        dly = (slp ? wake_t : rst_t) - t_kick;
        check(dly >= T && dly <= T + SLACK, req, dly, T);
        if (slp) begin
            check(wake_cnt == w0 + 1 && rst_cnt == r0, "R7",
                  longint'(rst_cnt - r0), 0);
        end else begin
            check(rst_cnt == r0 + 1 && wake_cnt == w0, req,
                  longint'(wake_cnt - w0), 0);
        end
        check(to_n == 1'b0, "R8", longint'(to_n), 0);
    endtask

    initial begin : watchdog
        #3_000_000;
        errors++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        longint t1;
        int     c;
        int     n;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (10) @(negedge sys_clk);
        check(to_n == 1'b1 && rst_req == 1'b0 && wake_req == 1'b0, "R1",
              longint'({to_n, rst_req, wake_req}), 4);
        rst_n = 1'b1;
        repeat (3) @(negedge sys_clk);
        check(to_n == 1'b1 && rst_req == 1'b0 && wake_req == 1'b0, "R1",
              longint'({to_n, rst_req, wake_req}), 4);

        // R9: disabled watchdog stays silent, even when strobed
        ps_assign = 1'b0;
        strobe(1'b0);
        repeat (int'(3 * period_ns(0, 0) / SPER)) @(negedge sys_clk);
        check(rst_cnt == 0 && wake_cnt == 0, "R9", longint'(rst_cnt + wake_cnt), 0);
        check(to_n == 1'b1, "R9", longint'(to_n), 1);

        // R2: base period only
        measure(1'b0, 0, 1'b0, 0, 1'b0, "R2");
        // R4: ratio select ignored when not assigned
        measure(1'b0, 7, 1'b0, 0, 1'b0, "R4");
        // R3: directed ratios, including 1:1 and 1:128
        measure(1'b1, 0, 1'b0, 0, 1'b0, "R3");
        measure(1'b1, 3, 1'b0, 0, 1'b0, "R3");
        measure(1'b1, 7, 1'b0, 0, 1'b0, "R3");
        // R7: timeout during sleep gives a wake-up
        measure(1'b1, 1, 1'b1, 0, 1'b1, "R7");
        // R5: periodic clears keep it quiet, last one restarts
        measure(1'b1, 2, 1'b0, 4, 1'b0, "R5");
        // R6: sleep-entry strobe restarts like a clear
        measure(1'b1, 2, 1'b0, 3, 1'b1, "R6");

        // R10: without a restart the next timeout is one full period later
        measure(1'b1, 1, 1'b0, 0, 1'b0, "R10");
        t1 = rst_t;
        c  = rst_cnt;
        n  = 0;
        while (rst_cnt == c && n < int'(period_ns(1, 1) / SPER) + 200) begin
            @(negedge sys_clk);
            n++;
        end
        check((rst_t - t1) >= period_ns(1, 1) - 100 && (rst_t - t1) <= period_ns(1, 1) + 100,
              "R10", rst_t - t1, period_ns(1, 1));

        // Random configurations
        for (int it = 0; it < 8; it++) begin
            bit a;
            int sel;
            bit slp;
            a   = 1'($urandom % 2);
            sel = int'($urandom % 6);
            slp = 1'($urandom % 2);
            measure(a, sel, slp, int'($urandom % 2), 1'($urandom % 2), a ? "R3" : "R4");
        end

        // R8: flag survives restarts, cleared only by power-on reset
        setup(1'b0, 0, 1'b0);
        strobe(1'b0);
        repeat (5) @(negedge sys_clk);
        check(to_n == 1'b0, "R8", longint'(to_n), 0);
        cfg_en = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge sys_clk);
        check(to_n == 1'b1, "R8", longint'(to_n), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge sys_clk);

        // R11: pulse width and exclusivity across the whole run
        check(long_cnt == 0, "R11", longint'(long_cnt), 0);
        check(both_cnt == 0, "R11", longint'(both_cnt), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule